// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. A producer presents a byte together with a one-cycle write strobe. The byte goes into a four-entry queue. A frame engine takes bytes from the queue one at a time and shifts each one out at a rate set by a clock divisor. Each frame has a start bit, eight data bits, an optional parity bit and one or two stop bits.

When flow control is switched on, the engine opens a new frame only while the active-low clear-to-send input is asserted, as seen after a two-flop synchronizer. The decision is made only at the frame boundary. A frame that has already started always runs to its last stop bit, so dropping the permission mid-frame only holds back the next byte. The frame settings (divisor, parity, stop count) are captured when a frame starts, and stay fixed for that frame.

Top module: `uart_cts_tx`

## Requirements
- R1: While reset is held and right after it, `txd` is high, `busy` low, `fifo_empty` high, `fifo_full` low and `ovf` low.
- R2: A frame begins with one low start bit, followed by data bits 0 to 7 in that order. Every bit holds `txd` for `baud_div` clocks, and a divisor of 0 acts as 1.
- R3: With `par_en` high, bit position 9 of the frame is a parity bit. With `par_odd` low it makes the count of ones over the data and parity even, and with `par_odd` high it makes that count odd. With `par_en` low, no parity bit is sent.
- R4: The frame ends with one high stop bit, or two when `two_stop` is high. `txd` is high whenever no frame is in progress, and at least one idle clock separates consecutive frames.
- R5: The queue holds up to 4 bytes, and bytes leave in the order they were written.
- R6: A write while `fifo_full` is high is discarded, and `ovf` goes high for the single following clock.
- R7: With `flow_en` high, a frame starts only when `cts_n` has been low through two synchronizer stages. While `cts_n` stays high, no frame starts.
- R8: If `cts_n` rises while a frame is in progress, that frame completes in full and the next queued byte waits.
- R9: With `flow_en` low, `cts_n` has no effect, and a frame starts on the clock after the queue becomes non-empty while the line is idle.
- R10: `busy` goes high in the clock the start bit appears and falls when the last stop bit ends.
- R11: `fifo_full` is high exactly when 4 bytes are queued, and `fifo_empty` is high exactly when none are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| flow_en | input | 1 | Enable gating by clear-to-send |
| par_en | input | 1 | Send a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| baud_div | input | 16 | Clocks per bit (0 treated as 1) |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | Frame in progress |
| fifo_full | output | 1 | Queue holds 4 bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| ovf | output | 1 | One-cycle pulse on a dropped write |

## Verification
The line is compared clock by clock against a behavioural model. The test bytes are 0x00, 0xFF, 0xA5 and 0x01, which separate bit-order faults from stuck data bits. The same bytes are run with parity off, even and odd, and with one or two stop bits. This shows whether the parity sense or the frame length is wrong. Divisors of 0, 1, 2 and 3 expose off-by-one bit timing. A burst of six writes during a frame checks the queue order and the drop on a full queue. The clear-to-send patterns cover four cases: held high, released, raised mid-frame, and ignored with flow control off. Together they show whether the gate is applied at the frame boundary or inside a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int DIV_W   = 16;

  function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // LSB first: start, data, parity-or-stop, stop, stop
  function automatic logic [FRAME_W-1:0] frame_vec(input logic [DATA_W-1:0] d,
                                                   input logic pe, input logic odd);
    return {2'b11, (pe ? par_bit(d, odd) : 1'b1), d, 1'b0};
  endfunction

  function automatic logic [3:0] frame_bits(input logic pe, input logic two);
    return 4'(DATA_W + 2) + 4'(pe) + 4'(two);
  endfunction

  function automatic logic [DIV_W-1:0] div_last(input logic [DIV_W-1:0] div);
    return (div == '0) ? '0 : div - 1'b1;
  endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = wr_en && !full;
  assign rd_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0;
    end else begin
      ovf <= wr_en && full;
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en)   rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_data;
  end

  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == CW'(DEPTH)));
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/tx_baud.sv
module tx_baud
  import uart_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end
);
  logic [DIV_W-1:0] cnt, last;

  assign bit_end = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; last <= '0;
    end else if (start) begin
      cnt <= '0; last <= div_last(div);
    end else if (run) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              bit_end,
  input  logic [DATA_W-1:0] data,
  input  logic              pe,
  input  logic              odd,
  input  logic              two,
  output logic              txd,
  output logic              busy
);
  logic [FRAME_W-1:0] sh;
  logic [3:0]         left;
  logic               last_bit;

  assign last_bit = bit_end && (left == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; left <= '0; txd <= 1'b1; busy <= 1'b0;
    end else if (go) begin
      sh   <= frame_vec(data, pe, odd);
      left <= frame_bits(pe, two) - 4'd1;
      txd  <= 1'b0;
      busy <= 1'b1;
    end else if (last_bit) begin
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (bit_end) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      txd  <= sh[1];
      left <= left - 4'd1;
    end
  end

  p_busy_ends_on_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> busy);
  p_no_go_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flow_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              cts_n,
  output logic              txd,
  output logic              busy,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              ovf
);
  logic              cts_m, cts_s;
  logic              cts_ok, frame_go, bit_end;
  logic [DATA_W-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_m <= 1'b1; cts_s <= 1'b1;
    end else begin
      cts_m <= cts_n; cts_s <= cts_m;
    end
  end

  assign cts_ok   = !flow_en || !cts_s;
  assign frame_go = !busy && !fifo_empty && cts_ok;

  tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(frame_go), .rd_data(head), .full(fifo_full),
    .empty(fifo_empty), .ovf(ovf));

  tx_baud u_baud (
    .clk(clk), .rst_n(rst_n), .start(frame_go), .run(busy),
    .div(baud_div), .bit_end(bit_end));

  tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .go(frame_go), .bit_end(bit_end),
    .data(head), .pe(par_en), .odd(par_odd), .two(two_stop),
    .txd(txd), .busy(busy));

  p_start_needs_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(flow_en)) |-> $past(cts_s) == 1'b0);
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(fifo_full));
endmodule

// File: tb/test_uart_cts_tx.sv
module test_uart_cts_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic flow_en = 0, par_en = 0, par_odd = 0, two_stop = 0, cts_n = 1;
  logic [15:0] baud_div = 16'd3;
  logic txd, busy, fifo_full, fifo_empty, ovf;

  int checks = 0, errors = 0, frames_seen = 0;
  bit done = 0;

  uart_cts_tx i_uart_cts_tx (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  byte unsigned q[$];
  bit m_busy, m_txd = 1, m_ovf, s1 = 1, s2 = 1;
  int idx, cnt, nb, dv;
  bit bits[12];

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_txd = 1; m_ovf = 0; s1 = 1; s2 = 1;
    end else begin
      bit full_pre, empty_pre, go;
      full_pre  = (q.size() == 4);
      empty_pre = (q.size() == 0);
      go = !m_busy && !empty_pre && (!flow_en || !s2);
      if (m_busy) begin
        if (cnt == dv - 1) begin
          cnt = 0;
          if (idx == nb - 1) begin m_busy = 0; m_txd = 1; end
          else begin idx++; m_txd = bits[idx]; end
        end else cnt++;
      end else if (go) begin
        byte unsigned b;
        int ones;
        b = q.pop_front();
        ones = 0;
        bits[0] = 0;
        for (int i = 0; i < 8; i++) begin bits[i+1] = b[i]; ones += b[i]; end
        nb = 9;
        if (par_en) begin bits[9] = par_odd ? (ones % 2 == 0) : (ones % 2 == 1); nb = 10; end
        bits[nb] = 1; nb++;
        if (two_stop) begin bits[nb] = 1; nb++; end
        dv = (baud_div == 0) ? 1 : int'(baud_div);
        m_busy = 1; idx = 0; cnt = 0; m_txd = 0;
      end
      s2 = s1; s1 = cts_n;
      m_ovf = wr_en && full_pre;
      if (wr_en && !full_pre) q.push_back(wr_data);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  bit busy_d;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string rq;
      if (!m_busy) rq = "R4 idle";
      else if (idx == 0) rq = "R2 start";
      else if (idx <= 8) rq = "R2 R5 data";
      else if (par_en && idx == 9) rq = "R3 parity";
      else rq = "R4 stop";
      chk(rq, txd, m_txd);
      chk("R10 busy", busy, m_busy);
      chk("R11 full", fifo_full, q.size() == 4);
      chk("R11 empty", fifo_empty, q.size() == 0);
      chk("R6 ovf", ovf, m_ovf);
      if (busy_d && !busy) frames_seen++;
      busy_d = busy;
    end
  end

  task automatic put(input byte unsigned b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (m_busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 busy", busy, 0);
    chk("R1 empty", fifo_empty, 1); chk("R1 full", fifo_full, 0);
    chk("R1 ovf", ovf, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd after reset", txd, 1);

    // plain frames, R2
    put(8'hA5); put(8'h01); drain();
    // even parity, two stops, R3 R4
    baud_div = 2; par_en = 1; two_stop = 1;
    put(8'h00); put(8'hFF); put(8'h01); drain();
    // odd parity, R3
    par_odd = 1; two_stop = 0;
    put(8'hA5); put(8'hFF); drain();
    // divisor 0 and 1, R2
    par_en = 0; baud_div = 0; put(8'h5A); drain();
    baud_div = 1; put(8'hC3); drain();

    // burst into full queue, R5 R6
    baud_div = 3;
    for (int i = 0; i < 6; i++) put(8'(8'h10 + i));
    drain();

    // flow control held off, R7
    flow_en = 1; cts_n = 1;
    put(8'h3C);
    repeat (40) @(negedge clk);
    chk("R7 held while cts high", busy, 0);
    chk("R7 byte still queued", fifo_empty, 0);
    cts_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 starts after sync", busy, 1);
    // R8: raise mid-frame
    put(8'h81);
    repeat (5) @(negedge clk);
    f0 = frames_seen;
    cts_n = 1;
    repeat (60) @(negedge clk);
    chk("R8 frame finished", frames_seen - f0, 1);
    chk("R8 next held", busy, 0);
    chk("R8 next queued", fifo_empty, 0);

    // R9: flow off ignores cts
    flow_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 starts with cts high", busy, 1);
    drain();
    put(8'hE7);
    @(negedge clk);
    chk("R9 immediate start", busy, 1);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule